// File: doc/BRIEF.md
# Display timing generator with shadowed configuration

This block produces the pixel, line and frame timing for a parallel video output. It creates horizontal sync, vertical sync, a data-enable strobe and the coordinates of the active pixel. It also raises single-cycle event strobes at each frame start, when a configuration update takes effect, when output ends, on each tearing-effect edge, and whenever active video is shown with no pixel available. Each timing setting exists twice. Software writes a shadow copy through a small write port. The counters run only from a live copy, and the live copy is loaded at well-defined moments.

There are two ways of operating. In continuous mode the frames run back to back. An update request copies the shadow settings into the live settings at the next frame boundary, which is the first cycle of vertical sync, so no frame mixes old and new settings. A stop request lets the current frame finish and then halts the output. In command mode the shadow is not used while a frame runs. Each rising edge of the run input captures the settings and sends exactly one frame. When the tearing-effect gate is enabled, that frame waits for a rising edge on the tearing-effect input before it starts.

Top module: `vid_timing_gen`

## Requirements
- R1: After reset the block is idle. hsync, vsync, de, pix_x, pix_y and every event output are 0.
- R2: The horizontal word (wr_sel=1) holds sync length in bits [7:0], back porch in bits [19:8] and front porch in bits [31:20]. Within each line, hsync is high for the first sync-length cycles. de can only be high in the active window, which starts after sync plus back porch and lasts for the active width. The line period is sync + back porch + active + front porch. pix_x counts from 0 across the active window.
- R3: The size word (wr_sel=0) holds the active line count in bits [31:16] and the active pixels per line in bits [15:0]. The vertical word (wr_sel=2) uses the same field layout as the horizontal word, counted in lines. vsync is high for the first sync-length lines of each frame. de is high only on active lines, and pix_y counts from 0 on those lines. de is never high together with hsync or vsync.
- R4: evt_vsync pulses for exactly one cycle at the first cycle of each frame, and that cycle is also the first cycle of vsync and of hsync.
- R5: In continuous mode (cmd_mode=0), a rising edge of run while idle loads the shadow settings. Frames then repeat back to back with no gap.
- R6: While frames run in continuous mode, shadow writes have no effect on their own. After upd_req, the new settings start at the next frame boundary. evt_upd_done pulses in that first cycle, together with evt_vsync.
- R7: In continuous mode, stop_req lets the current frame complete. The block then goes idle, evt_done pulses in the first idle cycle, and all timing outputs stay low.
- R8: In command mode (cmd_mode=1), each rising edge of run while idle captures the shadow settings and sends exactly one frame. evt_done then pulses in the first idle cycle. Shadow writes made during that frame do not change it.
- R9: With te_en=1 in command mode, the frame after a run edge waits for a rising edge of te_in. The frame starts in the cycle after that edge. evt_te is high in any cycle where te_in is high and was low at the previous clock.
- R10: evt_uflow is high in every cycle where de is high and pix_valid is low, and in no other cycle.
- R11: In command mode upd_req has no effect, and evt_upd_done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 2 | Shadow word select: 0 size, 1 horizontal, 2 vertical |
| wr_data | input | 32 | Shadow write data |
| run | input | 1 | Start level; a rising edge starts output |
| stop_req | input | 1 | Continuous-mode stop request pulse |
| upd_req | input | 1 | Continuous-mode update request pulse |
| cmd_mode | input | 1 | 1 selects command mode, 0 continuous |
| te_en | input | 1 | Gate command frames on te_in |
| te_in | input | 1 | Tearing-effect input from the panel |
| pix_valid | input | 1 | Pixel data available from the fetch path |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pix_x | output | 16 | Active pixel column |
| pix_y | output | 16 | Active line number |
| evt_vsync | output | 1 | Frame-start pulse |
| evt_upd_done | output | 1 | Update-applied pulse |
| evt_done | output | 1 | Output-ended pulse |
| evt_te | output | 1 | Tearing-effect edge pulse |
| evt_uflow | output | 1 | Underflow error strobe |

## Verification
The assertions assume that every live timing field is sane: sync lengths and active sizes are at least 1, so a frame is longer than one cycle and the active window lies strictly after sync. They also assume that te_in and the request inputs are synchronous to clk. The stimulus writes only non-zero sync lengths and active sizes. It changes every input at the falling clock edge and holds request pulses for exactly one cycle. It never writes a size word whose dimensions exceed the 16-bit fields.

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
  parameter int SYNC_W  = 8,
  parameter int PORCH_W = 12,
  parameter int ACT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             run,
  input  logic             stop_req,
  input  logic             upd_req,
  input  logic             cmd_mode,
  input  logic             te_en,
  input  logic             te_in,
  input  logic             pix_valid,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [ACT_W-1:0] pix_x,
  output logic [ACT_W-1:0] pix_y,
  output logic             evt_vsync,
  output logic             evt_upd_done,
  output logic             evt_done,
  output logic             evt_te,
  output logic             evt_uflow
);
  localparam int TW     = ACT_W + 2;
  localparam int BP_LSB = SYNC_W;
  localparam int FP_LSB = SYNC_W + PORCH_W;
  localparam int WW     = 2 * ACT_W;

  typedef enum logic [1:0] {IDLE, WAIT_TE, SCAN} st_t;
  st_t st;

  logic [WW-1:0] sh_size, sh_htim, sh_vtim;
  logic [WW-1:0] lv_size, lv_htim, lv_vtim;
  logic [TW-1:0] hc, vc;
  logic mode_q, run_q, te_q, stop_pend, upd_pend;

  logic [TW-1:0] h_s, h_b, h_f, h_a, v_s, v_b, v_f, v_a;
  assign h_s = TW'(lv_htim[SYNC_W-1:0]);
  assign h_b = TW'(lv_htim[FP_LSB-1:BP_LSB]);
  assign h_f = TW'(lv_htim[WW-1:FP_LSB]);
  assign h_a = TW'(lv_size[ACT_W-1:0]);
  assign v_s = TW'(lv_vtim[SYNC_W-1:0]);
  assign v_b = TW'(lv_vtim[FP_LSB-1:BP_LSB]);
  assign v_f = TW'(lv_vtim[WW-1:FP_LSB]);
  assign v_a = TW'(lv_size[WW-1:ACT_W]);

  logic [TW-1:0] h_as, v_as, h_tot, v_tot;
  assign h_as  = h_s + h_b;
  assign v_as  = v_s + v_b;
  assign h_tot = h_as + h_a + h_f;
  assign v_tot = v_as + v_a + v_f;

  logic scan, h_last, v_last, frame_end, take_stop, take_upd, run_rise;
  assign scan      = (st == SCAN);
  assign h_last    = (hc == h_tot - TW'(1));
  assign v_last    = (vc == v_tot - TW'(1));
  assign frame_end = scan && h_last && v_last;
  assign take_stop = frame_end && (mode_q || stop_pend);
  assign take_upd  = frame_end && !take_stop && upd_pend;
  assign run_rise  = run && !run_q;

  assign hsync     = scan && (hc < h_s);
  assign vsync     = scan && (vc < v_s);
  assign de        = scan && (hc >= h_as) && (hc < h_as + h_a) &&
                     (vc >= v_as) && (vc < v_as + v_a);
  assign pix_x     = de ? ACT_W'(hc - h_as) : '0;
  assign pix_y     = de ? ACT_W'(vc - v_as) : '0;
  assign evt_vsync = scan && (hc == '0) && (vc == '0);
  assign evt_te    = te_in && !te_q;
  assign evt_uflow = de && !pix_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      sh_size <= '0; sh_htim <= '0; sh_vtim <= '0;
      lv_size <= '0; lv_htim <= '0; lv_vtim <= '0;
      hc <= '0; vc <= '0;
      mode_q <= 1'b0; run_q <= 1'b0; te_q <= 1'b0;
      stop_pend <= 1'b0; upd_pend <= 1'b0;
      evt_upd_done <= 1'b0; evt_done <= 1'b0;
    end else begin
      run_q <= run;
      te_q  <= te_in;
      evt_upd_done <= take_upd;
      evt_done     <= take_stop;
      if (wr_en) begin
        case (wr_sel)
          2'd0:    sh_size <= wr_data;
          2'd1:    sh_htim <= wr_data;
          2'd2:    sh_vtim <= wr_data;
          default: ;
        endcase
      end
      case (st)
        IDLE: if (run_rise) begin
          lv_size <= sh_size; lv_htim <= sh_htim; lv_vtim <= sh_vtim;
          mode_q <= cmd_mode;
          hc <= '0; vc <= '0;
          stop_pend <= 1'b0; upd_pend <= 1'b0;
          st <= (cmd_mode && te_en) ? WAIT_TE : SCAN;
        end
        WAIT_TE: if (evt_te) st <= SCAN;
        default: begin
          stop_pend <= (stop_pend && !frame_end) || (stop_req && !mode_q);
          upd_pend  <= (upd_pend && !take_upd) || (upd_req && !mode_q);
          if (h_last) begin
            hc <= '0;
            vc <= v_last ? '0 : vc + TW'(1);
          end else begin
            hc <= hc + TW'(1);
          end
          if (take_stop) st <= IDLE;
          if (take_upd) begin
            lv_size <= sh_size; lv_htim <= sh_htim; lv_vtim <= sh_vtim;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk #(
  parameter int ACT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [ACT_W-1:0] pix_x,
  input logic [ACT_W-1:0] hact,
  input logic             evt_vsync,
  input logic             evt_upd_done,
  input logic             evt_done,
  input logic             evt_uflow
);
  assert_x_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> pix_x < hact) else $error("pix_x outside active width");

  assert_de_blanked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !hsync && !vsync) else $error("de during sync");

  assert_frame_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vsync |-> vsync && hsync) else $error("frame pulse outside sync start");

  assert_frame_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vsync |=> !evt_vsync) else $error("frame pulse longer than one cycle");

  assert_update_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_upd_done |-> evt_vsync) else $error("update done away from frame start");

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !hsync && !vsync && !de) else $error("done while scanning");

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !evt_done) else $error("done longer than one cycle");

  assert_uflow_in_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_uflow |-> de) else $error("underflow outside active video");
endmodule

bind vid_timing_gen vid_timing_gen_chk #(.ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .de(de),
  .pix_x(pix_x), .hact(lv_size[ACT_W-1:0]), .evt_vsync(evt_vsync),
  .evt_upd_done(evt_upd_done), .evt_done(evt_done), .evt_uflow(evt_uflow)
);

// File: tb/vid_timing_gen_tb.sv
module vid_timing_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, run = 1'b0, stop_req = 1'b0, upd_req = 1'b0;
  logic cmd_mode = 1'b0, te_en = 1'b0, te_in = 1'b0, pix_valid = 1'b1;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic hsync, vsync, de, evt_vsync, evt_upd_done, evt_done, evt_te, evt_uflow;
  logic [15:0] pix_x, pix_y;

  int n_run = 0, n_fail = 0;
  int c_hs, c_vs, c_de, c_ev, c_ud, c_uf, s_x, s_y;

  // Config A: hs2 hbp1 hact4 hfp1 (8/line), vs1 vbp1 vact3 vfp1 (6 lines) -> 48 cycles
  localparam logic [31:0] H_A = 32'h0010_0102, S_A = 32'h0003_0004;
  // Config B: hs3 hbp2 hact5 hfp2 (12/line) -> 72 cycles
  localparam logic [31:0] H_B = 32'h0020_0203, S_B = 32'h0003_0005;
  localparam logic [31:0] V_A = 32'h0010_0101;

  always #5 clk = ~clk;

  vid_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run(run), .stop_req(stop_req), .upd_req(upd_req), .cmd_mode(cmd_mode),
    .te_en(te_en), .te_in(te_in), .pix_valid(pix_valid),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .evt_vsync(evt_vsync), .evt_upd_done(evt_upd_done), .evt_done(evt_done),
    .evt_te(evt_te), .evt_uflow(evt_uflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int len);
    c_hs = 0; c_vs = 0; c_de = 0; c_ev = 0; c_ud = 0; c_uf = 0; s_x = 0; s_y = 0;
    len = 0;
    do begin
      c_hs += int'(hsync); c_vs += int'(vsync); c_de += int'(de);
      c_ev += int'(evt_vsync); c_ud += int'(evt_upd_done); c_uf += int'(evt_uflow);
      if (de) begin s_x += int'(pix_x); s_y += int'(pix_y); end
      len++;
      @(negedge clk);
    end while (!evt_vsync && !evt_done && len < 1000);
  endtask

  task automatic t_reset;
    chk("R1 idle outputs", int'({hsync, vsync, de, evt_vsync, evt_upd_done,
        evt_done, evt_te, evt_uflow}), 0);
    chk("R1 coords", int'(pix_x) + int'(pix_y), 0);
  endtask

  task automatic t_continuous;
    int len;
    wr(0, S_A); wr(1, H_A); wr(2, V_A);
    run = 1'b1;
    @(negedge clk);
    chk("R4 first cycle sync", int'({evt_vsync, vsync, hsync, de}), 4'b1110);
    for (int f = 0; f < 2; f++) begin
      measure(len);
      chk("R5 frame length", len, 48);
      chk("R2 hsync cycles", c_hs, 12);
      chk("R3 vsync cycles", c_vs, 8);
      chk("R2 de cycles", c_de, 12);
      chk("R4 one frame pulse", c_ev, 1);
      chk("R2 pix_x sum", s_x, 18);
      chk("R3 pix_y sum", s_y, 12);
      chk("R10 no underflow", c_uf, 0);
      chk("R5 next frame starts", int'(evt_vsync), 1);
    end
  endtask

  task automatic t_update;
    int len;
    wr(1, H_B); wr(0, S_B);
    upd_req = 1'b1; @(negedge clk); upd_req = 1'b0;
    measure(len);
    chk("R6 old timing kept", len, 45);
    chk("R6 old hsync kept", c_hs, 10);
    chk("R6 no early update", c_ud, 0);
    chk("R6 update done at frame", int'({evt_upd_done, evt_vsync}), 3);
    measure(len);
    chk("R6 new frame length", len, 72);
    chk("R6 new de cycles", c_de, 15);
    chk("R2 new hsync cycles", c_hs, 18);
    chk("R2 new pix_x sum", s_x, 30);
    chk("R3 new pix_y sum", s_y, 15);
    chk("R6 single update", int'(evt_upd_done), 0);
  endtask

  task automatic t_stop;
    int len, seen;
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    measure(len);
    chk("R7 frame completes", len, 71);
    chk("R7 done pulse", int'(evt_done), 1);
    chk("R7 no new frame", int'(evt_vsync), 0);
    @(negedge clk);
    chk("R7 done one cycle", int'(evt_done), 0);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      seen += int'(hsync) + int'(vsync) + int'(de);
      @(negedge clk);
    end
    chk("R7 outputs stay low", seen, 0);
  endtask

  task automatic t_command;
    int len, seen;
    run = 1'b0; cmd_mode = 1'b1; te_en = 1'b0;
    wr(1, H_A); wr(0, S_A);
    run = 1'b1; @(negedge clk);
    chk("R8 frame starts on run edge", int'(evt_vsync), 1);
    wr(1, H_B);
    upd_req = 1'b1; @(negedge clk); upd_req = 1'b0;
    measure(len);
    chk("R8 captured timing used", len, 46);
    chk("R8 captured hsync", c_hs, 10);
    chk("R11 no update in command", c_ud, 0);
    chk("R8 done after frame", int'(evt_done), 1);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      seen += int'(evt_vsync) + int'(hsync) + int'(evt_upd_done);
      @(negedge clk);
    end
    chk("R8 exactly one frame", seen, 0);
    chk("R11 still no update", int'(evt_upd_done), 0);
    wr(0, S_B);
    run = 1'b0; @(negedge clk);
    run = 1'b1; @(negedge clk);
    measure(len);
    chk("R8 new capture length", len, 72);
    chk("R8 new capture de", c_de, 15);
    chk("R8 second done", int'(evt_done), 1);
  endtask

  task automatic t_te;
    int len, seen;
    run = 1'b0; te_en = 1'b1; pix_valid = 1'b0;
    @(negedge clk);
    run = 1'b1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      seen += int'(hsync) + int'(vsync) + int'(evt_vsync);
    end
    chk("R9 waits for te", seen, 0);
    te_in = 1'b1; #1;
    chk("R9 te pulse", int'(evt_te), 1);
    @(negedge clk);
    chk("R9 te pulse one cycle", int'(evt_te), 0);
    chk("R9 frame after te", int'(evt_vsync), 1);
    te_in = 1'b0;
    measure(len);
    chk("R9 gated frame length", len, 72);
    chk("R10 underflow on every de", c_uf, 15);
    chk("R10 de count", c_de, 15);
    pix_valid = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_continuous();
    t_update();
    t_stop();
    t_command();
    t_te();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule